// File: doc/BRIEF.md
# Master Clock Ratio Monitor

This block watches a converter's master clock and its left/right frame clock and reports two faults to a downstream mute controller. It counts master clock cycles from one rising edge of the frame clock to the next. It compares each count with the ratio picked by a 2-bit ratio code and a base/high rate flag. A debounce state machine turns those comparisons into a ratio-error flag. A single bad period is absorbed. Two bad periods in a row raise the flag, and two good periods in a row clear it.

A second state machine runs on a free-running reference clock and checks that the master clock is alive. A toggle flop in the master clock domain is synchronised into the reference domain, and every change seen there restarts an idle counter. If no change arrives for `TIMEOUT` reference cycles, the clock-valid flag drops. The frame clock input must already be synchronous to the master clock. Reset forces both flags into their fault state.

The period counter has two states: `CNT_IDLE` and `CNT_MEASURE`. Transition: the first frame-clock rise moves it to `CNT_MEASURE`.

The ratio filter has four states: `FLT_FAULT`, `FLT_FAULT_ONE_OK`, `FLT_GOOD` and `FLT_GOOD_ONE_BAD`. Transitions:
- On a match, `FLT_FAULT` goes to `FLT_FAULT_ONE_OK`.
- On a match, `FLT_FAULT_ONE_OK` and `FLT_GOOD_ONE_BAD` go to `FLT_GOOD`.
- On a mismatch, `FLT_GOOD` goes to `FLT_GOOD_ONE_BAD`.
- On a mismatch, `FLT_GOOD_ONE_BAD` and `FLT_FAULT_ONE_OK` go to `FLT_FAULT`.

The watchdog has two states: `WD_DEAD` and `WD_ALIVE`. Transitions:
- A seen toggle moves it from `WD_DEAD` to `WD_ALIVE`.
- An idle timeout moves it from `WD_ALIVE` back to `WD_DEAD`.

Top module: `mclk_ratio_monitor`

## Requirements
- R1: With `hi_rate`=0, `ratio_sel` values 0, 1, 2 and 3 accept periods of exactly 128, 256, 384 and 512 master clock cycles.
- R2: With `hi_rate`=1, `ratio_sel` values 0, 1, 2 and 3 accept periods of exactly 64, 128, 192 and 256 master clock cycles.
- R3: A period is the number of master clock cycles from one rising `lrck` edge to the next. The first rise after reset only starts counting and is never judged. A period one cycle off the target counts as a mismatch.
- R4: `ratio_err` rises only after two consecutive mismatched periods. A single mismatched period between matches leaves it low.
- R5: `ratio_err` falls only after two consecutive matched periods. One match after a fault leaves it high.
- R6: `mclk_ok` goes high within a few reference cycles once the master clock toggles.
- R7: `mclk_ok` goes low once the master clock has stopped for `TIMEOUT` reference cycles. `ratio_err` holds its value while the master clock is stopped.
- R8: While `rst_n` is low, `mclk_ok` is 0 and `ratio_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Free-running reference clock for the watchdog |
| mclk | input | 1 | Monitored master clock |
| lrck | input | 1 | Frame clock, synchronous to `mclk` |
| hi_rate | input | 1 | 1 selects the high rate ratio set |
| ratio_sel | input | 2 | Ratio code 0..3 |
| mclk_ok | output | 1 | Master clock running (reference domain) |
| ratio_err | output | 1 | Debounced ratio fault (master clock domain) |

## Verification
If the filter holds the wrong state, the fault shows up late or not at all. `ratio_err` then moves after the first of two matching or mismatching periods instead of the second, or it ignores a second consecutive period. The bench catches this within one frame by sampling a few master cycles after each judged edge. A wrong count or arming state shows as a judgement made on a period one cycle off target, or on the partial period after reset. A watchdog counter that never expires, or a synchroniser that misses changes, shows on `mclk_ok` within a few dozen reference cycles after the clock is stopped or restarted.

// File: rtl/mcrm_pkg.sv
package mcrm_pkg;

    typedef enum logic {
        CNT_IDLE,
        CNT_MEASURE
    } cnt_state_e;

    typedef enum logic [1:0] {
        FLT_FAULT,
        FLT_FAULT_ONE_OK,
        FLT_GOOD,
        FLT_GOOD_ONE_BAD
    } flt_state_e;

    typedef enum logic {
        WD_DEAD,
        WD_ALIVE
    } wd_state_e;

    // Cycles per frame: high rate halves the base unit, the code scales it 1x..4x.
    function automatic int unsigned ratio_target(logic hi, logic [1:0] sel,
                                                 int unsigned base_unit);
        int unsigned unit;
        unit = hi ? (base_unit / 32'd2) : base_unit;
        return unit * (32'(sel) + 32'd1);
    endfunction

endpackage

// File: rtl/mcrm_period_counter.sv
module mcrm_period_counter #(
    parameter int unsigned BASE_UNIT = 128,
    parameter int unsigned CNT_W     = 11
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       lrck,
    input  logic       hi_rate,
    input  logic [1:0] ratio_sel,
    output logic       period_done,
    output logic       period_match
);
    import mcrm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cnt_state_e       state_q, state_d;
    logic             lrck_q;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target;

    assign rise   = lrck & ~lrck_q;
    assign target = CNT_W'(ratio_target(hi_rate, ratio_sel, BASE_UNIT));

    // State register
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE:    if (rise) state_d = CNT_MEASURE;
            CNT_MEASURE: state_d = CNT_MEASURE;
            default:     state_d = CNT_IDLE;
        endcase
    end

    // Edge history and saturating cycle counter
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            lrck_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            lrck_q <= lrck;
            if (rise)                cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs: one pulse per judged period
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            period_done  <= 1'b0;
            period_match <= 1'b0;
        end else begin
            period_done  <= rise && (state_q == CNT_MEASURE);
            period_match <= rise && (cnt_q == target);
        end
    end

    p_done_pulse_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        period_done |=> !period_done);

    p_fresh_count_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        period_done |-> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/mcrm_ratio_filter.sv
module mcrm_ratio_filter (
    input  logic mclk,
    input  logic rst_n,
    input  logic period_done,
    input  logic period_match,
    output logic ratio_err
);
    import mcrm_pkg::*;

    flt_state_e state_q, state_d;

    // State register
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_FAULT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (period_done) begin
            unique case (state_q)
                FLT_FAULT:        state_d = period_match ? FLT_FAULT_ONE_OK : FLT_FAULT;
                FLT_FAULT_ONE_OK: state_d = period_match ? FLT_GOOD         : FLT_FAULT;
                FLT_GOOD:         state_d = period_match ? FLT_GOOD         : FLT_GOOD_ONE_BAD;
                FLT_GOOD_ONE_BAD: state_d = period_match ? FLT_GOOD         : FLT_FAULT;
                default:          state_d = FLT_FAULT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            FLT_FAULT, FLT_FAULT_ONE_OK: ratio_err = 1'b1;
            default:                     ratio_err = 1'b0;
        endcase
    end

    p_raise_on_bad_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(ratio_err) |-> $past(period_done && !period_match));

    p_hold_between_periods_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        !$past(period_done) |-> $stable(state_q));

    p_clear_on_good_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        $fell(ratio_err) |-> $past(period_done && period_match));

endmodule

// File: rtl/mcrm_clock_watchdog.sv
module mcrm_clock_watchdog #(
    parameter int unsigned TIMEOUT     = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic mclk,
    input  logic rst_n,
    output logic clk_ok
);
    import mcrm_pkg::*;

    localparam int unsigned IDLE_W = $clog2(TIMEOUT + 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT - 1);

    logic                 tog_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 tog_edge;
    logic [IDLE_W-1:0]    idle_q;
    wd_state_e            state_q, state_d;

    // Master-domain toggle
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    // Reference-domain synchroniser with one extra stage for change detection
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], tog_q};
    end

    assign tog_edge = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                                   idle_q <= '0;
        else if (tog_edge)                            idle_q <= '0;
        else if (state_q == WD_ALIVE && idle_q != IDLE_LAST) idle_q <= idle_q + 1'b1;
    end

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_DEAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_DEAD:  if (tog_edge) state_d = WD_ALIVE;
            WD_ALIVE: if (!tog_edge && idle_q == IDLE_LAST) state_d = WD_DEAD;
            default:  state_d = WD_DEAD;
        endcase
    end

    // Outputs
    always_comb clk_ok = (state_q == WD_ALIVE);

    p_alive_on_toggle_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(clk_ok) |-> $past(tog_edge));

    p_dead_after_idle_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(clk_ok) |-> ($past(idle_q) == IDLE_LAST));

endmodule

// File: rtl/mclk_ratio_monitor.sv
module mclk_ratio_monitor #(
    parameter int unsigned BASE_UNIT   = 128,
    parameter int unsigned TIMEOUT     = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       rst_n,
    input  logic       ref_clk,
    input  logic       mclk,
    input  logic       lrck,
    input  logic       hi_rate,
    input  logic [1:0] ratio_sel,
    output logic       mclk_ok,
    output logic       ratio_err
);
    localparam int unsigned MAX_RATIO = BASE_UNIT * 4;
    localparam int unsigned CNT_W     = $clog2(MAX_RATIO * 2) + 1;

    logic period_done;
    logic period_match;

    mcrm_period_counter #(
        .BASE_UNIT (BASE_UNIT),
        .CNT_W     (CNT_W)
    ) u_counter (
        .mclk         (mclk),
        .rst_n        (rst_n),
        .lrck         (lrck),
        .hi_rate      (hi_rate),
        .ratio_sel    (ratio_sel),
        .period_done  (period_done),
        .period_match (period_match)
    );

    mcrm_ratio_filter u_filter (
        .mclk         (mclk),
        .rst_n        (rst_n),
        .period_done  (period_done),
        .period_match (period_match),
        .ratio_err    (ratio_err)
    );

    mcrm_clock_watchdog #(
        .TIMEOUT     (TIMEOUT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_watchdog (
        .ref_clk (ref_clk),
        .mclk    (mclk),
        .rst_n   (rst_n),
        .clk_ok  (mclk_ok)
    );

    always @(posedge ref_clk) begin
        if (!rst_n) begin
            p_reset_flags_r8: assert (!mclk_ok && ratio_err);
        end
    end

endmodule

// File: tb/mclk_ratio_monitor_bench.sv
module mclk_ratio_monitor_bench;

    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       mclk = 1'b0;
    logic       mclk_run = 1'b1;
    logic       lrck = 1'b0;
    logic       hi_rate = 1'b0;
    logic [1:0] ratio_sel = 2'd1;
    logic       mclk_ok;
    logic       ratio_err;

    int checks = 0;
    int errors = 0;
    int next_n = 256;
    int ref_cycles = 0;
    event frame_start;
    event sample_ev;

    typedef struct {
        string req;
        bit    chk_ok;
        bit    exp_ok;
        bit    chk_err;
        bit    exp_err;
    } item_t;

    item_t exp_q[$];

    mclk_ratio_monitor u_mclk_ratio_monitor (
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .mclk      (mclk),
        .lrck      (lrck),
        .hi_rate   (hi_rate),
        .ratio_sel (ratio_sel),
        .mclk_ok   (mclk_ok),
        .ratio_err (ratio_err)
    );

    always #10 ref_clk = ~ref_clk;
    always #23 if (mclk_run) mclk = ~mclk;

    // Free-running frame generator: each frame lasts the length read at its start
    initial begin
        forever begin
            int n;
            n = next_n;
            -> frame_start;
            lrck = 1'b1;
            repeat (n / 2) @(negedge mclk);
            lrck = 1'b0;
            repeat (n - n / 2) @(negedge mclk);
        end
    end

    // Monitor: pops expected items and compares them at the ports
    initial begin
        forever begin
            @(sample_ev);
            @(negedge ref_clk);
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                if (it.chk_ok) begin
                    checks++;
                    if (mclk_ok !== it.exp_ok) begin
                        errors++;
                        $display("FAIL %s mclk_ok actual=%0b expected=%0b", it.req, mclk_ok, it.exp_ok);
                    end
                end
                if (it.chk_err) begin
                    checks++;
                    if (ratio_err !== it.exp_err) begin
                        errors++;
                        $display("FAIL %s ratio_err actual=%0b expected=%0b", it.req, ratio_err, it.exp_err);
                    end
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge ref_clk);
            ref_cycles++;
            if (ref_cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    task automatic push(string req, bit chk_ok, bit exp_ok, bit chk_err, bit exp_err);
        item_t it;
        it.req = req; it.chk_ok = chk_ok; it.exp_ok = exp_ok;
        it.chk_err = chk_err; it.exp_err = exp_err;
        exp_q.push_back(it);
        -> sample_ev;
        wait (exp_q.size() == 0);
    endtask

    // Expect ratio_err after the last judged edge has settled
    task automatic expect_err(string req, bit e);
        repeat (4) @(negedge mclk);
        push(req, 1'b0, 1'b0, 1'b1, e);
    endtask

    task automatic frames(int n, int k);
        next_n = n;
        repeat (k) @(frame_start);
    endtask

    task automatic set_mode(bit hi, logic [1:0] sel);
        repeat (4) @(negedge mclk);
        hi_rate   = hi;
        ratio_sel = sel;
    endtask

    initial begin
        // R8: reset state
        repeat (5) @(negedge ref_clk);
        push("R8 reset", 1'b1, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b1;

        // R6: clock seen after release
        repeat (20) @(negedge ref_clk);
        push("R6 clock present", 1'b1, 1'b1, 1'b0, 1'b0);

        // R3: first rise only arms
        frames(256, 1);  expect_err("R3 arming edge not judged", 1'b1);
        frames(256, 1);  expect_err("R5 one match keeps fault", 1'b1);
        frames(256, 1);  expect_err("R1 base code1 256 accepted", 1'b0);

        // R4: single bad period filtered
        frames(200, 1);
        frames(256, 1);  expect_err("R4 single mismatch filtered", 1'b0);
        frames(256, 1);
        frames(300, 2);  expect_err("R4 one mismatch keeps good", 1'b0);
        frames(256, 1);  expect_err("R4 two mismatches raise", 1'b1);
        frames(256, 1);  expect_err("R5 one match after fault", 1'b1);
        frames(256, 1);  expect_err("R5 two matches clear", 1'b0);

        // R2: high rate codes
        set_mode(1'b1, 2'd3);
        frames(256, 2);  expect_err("R2 high code3 256 accepted", 1'b0);
        set_mode(1'b1, 2'd0);
        frames(64, 2);
        frames(64, 1);   expect_err("R2 high code0 64 accepted", 1'b0);

        // R1: base codes
        set_mode(1'b0, 2'd2);
        frames(384, 3);  expect_err("R1 base code2 384 accepted", 1'b0);
        set_mode(1'b0, 2'd0);
        frames(256, 2);  expect_err("R1 base code0 rejects 256", 1'b1);
        frames(128, 3);  expect_err("R1 base code0 128 accepted", 1'b0);
        set_mode(1'b0, 2'd3);
        frames(512, 3);  expect_err("R1 base code3 512 accepted", 1'b0);

        set_mode(1'b1, 2'd1);
        frames(128, 3);  expect_err("R2 high code1 128 accepted", 1'b0);
        set_mode(1'b1, 2'd2);
        frames(192, 3);  expect_err("R2 high code2 192 accepted", 1'b0);

        // R3: one cycle off is a mismatch
        frames(193, 2);
        frames(193, 1);  expect_err("R3 off by one rejected", 1'b1);
        frames(192, 2);  expect_err("R3 recovery one match", 1'b1);
        frames(192, 1);  expect_err("R3 recovery two matches", 1'b0);

        // R7: stopped master clock
        repeat (4) @(negedge mclk);
        mclk_run = 1'b0;
        repeat (40) @(negedge ref_clk);
        push("R7 stopped clock detected, ratio_err held", 1'b1, 1'b0, 1'b1, 1'b0);

        // R6: restart
        mclk_run = 1'b1;
        repeat (20) @(negedge ref_clk);
        push("R6 restarted clock detected", 1'b1, 1'b1, 1'b0, 1'b0);

        // R8: reset while running
        rst_n = 1'b0;
        repeat (3) @(negedge ref_clk);
        push("R8 reset while running", 1'b1, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b1;
        repeat (20) @(negedge ref_clk);
        push("R6 clock after second reset", 1'b1, 1'b1, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule